// File: doc/BRIEF.md
# Two-Beat Burst Memory with Independent Read and Write Ports

This block is a synthesizable memory core with a read port and a write port that run without regard to each other. Every location holds 36 bits, moved as a pair of 18-bit beats on consecutive cycles of one clock. The low half of the location, bits 17:0, always travels first and the high half, bits 35:18, travels second.

A read is requested with a select and an address. The two beats come back one cycle later on a shared data bus, marked by a valid flag. The bus drops back to zero as soon as the burst ends, so bursts from several such blocks can be merged without gaps.

A write is requested with a select. The first beat and its lane mask are taken on that cycle, and the second beat, its mask and the address are taken on the next cycle. Each beat has two lane-enable bits, so single 9-bit halves can be updated. A read that overlaps a write to the same address sees the write's data, merged with the stored word lane by lane.

Top module: `qdr_burst2_sram`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `rd_valid` is 0 and `rd_data` is 0.
- R2: A read is accepted when `rd_sel` is 1 at a rising edge and no read was accepted on the edge before. `rd_addr` is captured on that edge. `rd_sel` on the edge right after an acceptance is ignored.
- R3: After a read is accepted at edge T, `rd_valid` is 1 and `rd_data` holds bits 17:0 of the location from edge T+1. From edge T+2 it holds bits 35:18.
- R4: After the second beat, `rd_valid` returns to 0 and `rd_data` to 0 at the next edge, unless a new burst starts there. Reads requested every second cycle give an unbroken stream of beats.
- R5: A write starts when `wr_sel` is 1 at an edge where no write is in its second cycle. That edge captures beat 0 (`wr_data`, `wr_bmask`). The next edge captures beat 1, its mask and `wr_addr`. `wr_sel` during that second cycle is ignored.
- R6: Mask bit 0 enables bits 8:0 of a beat and mask bit 1 enables bits 17:9. A lane whose bit is 0 keeps its stored value.
- R7: A read accepted at edge T returns the location as updated by every write whose first beat was taken at or before T. A read never sees a write whose first beat was taken after T. Partially masked writes are merged lane by lane.
- R8: Dropping `wr_sel` in the second write cycle does not cancel the write. Dropping `rd_sel` after acceptance does not cancel the read's two beats.
- R9: A read and a write may start on the same edge. Neither port delays or alters the other except through the data of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| rd_sel | input | 1 | Read request |
| rd_addr | input | AW | Read address, taken with the request |
| wr_sel | input | 1 | Write request |
| wr_addr | input | AW | Write address, taken in the second write cycle |
| wr_data | input | 18 | Write beat: low half first, then high half |
| wr_bmask | input | 2 | Lane enables for the current write beat |
| rd_data | output | 18 | Read beat, zero when idle |
| rd_valid | output | 1 | Read beat present |

## Verification
The hardest case to reach is a collision where a write is committing to an address on the exact edge a read of that address fetches it. It is hardest with a partial mask, because only some lanes should change. It is just as hard to show that a write starting one edge later stays invisible. Directed sequences place the write's first beat one edge before, on, and one edge after the read request. Each uses a distinct mask. A long random phase then confines both addresses to eight locations and draws random selects and masks, so these alignments recur many times. A bench model applies each write when its second beat is driven, and takes the read's expected value on the fetch cycle.

// File: rtl/qdr_burst2_sram.sv
module qdr_burst2_sram #(
  parameter int DEPTH  = 1024,
  parameter int WORD_W = 18,
  localparam int AW     = $clog2(DEPTH),
  localparam int LANE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        wr_bmask,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [2*WORD_W-1:0] mem [DEPTH];

  logic              wr_ph;
  logic [WORD_W-1:0] w0_d;
  logic [1:0]        w0_m;
  logic              rd_pend;
  logic [AW-1:0]     rd_a;
  logic [WORD_W-1:0] hi_q;
  logic              rd_beat;

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [1:0]        m
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int l = 0; l < 2; l++)
      if (m[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [2*WORD_W-1:0] wr_old, wr_word, rd_word, fetch_word;

  assign wr_old     = mem[wr_addr];
  assign wr_word    = {lane_merge(wr_old[2*WORD_W-1:WORD_W], wr_data, wr_bmask),
                       lane_merge(wr_old[WORD_W-1:0], w0_d, w0_m)};
  assign rd_word    = mem[rd_a];
  assign fetch_word = (wr_ph && wr_addr == rd_a) ? wr_word : rd_word;

  always_ff @(posedge clk)
    if (wr_ph) mem[wr_addr] <= wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ph    <= 1'b0;
      w0_d     <= '0;
      w0_m     <= '0;
      rd_pend  <= 1'b0;
      rd_a     <= '0;
      hi_q     <= '0;
      rd_beat  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      wr_ph <= !wr_ph && wr_sel;
      if (!wr_ph && wr_sel) begin
        w0_d <= wr_data;
        w0_m <= wr_bmask;
      end
      rd_pend <= !rd_pend && rd_sel;
      if (!rd_pend && rd_sel) rd_a <= rd_addr;
      if (rd_pend) begin
        rd_valid <= 1'b1;
        rd_data  <= fetch_word[WORD_W-1:0];
        hi_q     <= fetch_word[2*WORD_W-1:WORD_W];
        rd_beat  <= 1'b0;
      end else if (rd_valid && !rd_beat) begin
        rd_data  <= hi_q;
        rd_beat  <= 1'b1;
      end else begin
        rd_valid <= 1'b0;
        rd_data  <= '0;
        rd_beat  <= 1'b0;
      end
    end
  end

  a_r2_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> !rd_pend);

  a_r3_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && !rd_pend) |=> ##1 (rd_valid && !rd_beat) ##1 (rd_valid && rd_beat));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat && !rd_pend) |=> (!rd_valid && rd_data == '0));

  a_r5_two_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph |=> !wr_ph);

  a_r8_write_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_ph) |=> wr_ph);

endmodule

// File: tb/qdr_burst2_sram_bench.sv
module qdr_burst2_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel = 1'b0, wr_sel = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [1:0] wr_bmask = '0;
  logic [17:0] rd_data;
  logic rd_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_burst2_sram #(.DEPTH(DEPTH), .WORD_W(18)) u_qdr_burst2_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bmask(wr_bmask),
    .rd_data(rd_data), .rd_valid(rd_valid));

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0;
  string cur_tag = "R3";

  logic [35:0] model [DEPTH];
  int          exp_cyc[$];
  logic [17:0] exp_dat[$];
  string       exp_tag[$];

  bit          b_wph = 0, b_rpend = 0;
  logic [17:0] b_w0d;
  logic [1:0]  b_w0m;
  logic [AW-1:0] b_ra;

  function automatic logic [17:0] mrg(input logic [17:0] o, input logic [17:0] n, input logic [1:0] m);
    logic [17:0] r = o;
    if (m[0]) r[8:0]  = n[8:0];
    if (m[1]) r[17:9] = n[17:9];
    return r;
  endfunction

  task automatic step(input bit rs, input logic [AW-1:0] ra, input bit ws,
                      input logic [AW-1:0] wa, input logic [17:0] wd, input logic [1:0] wm);
    rd_sel = rs; rd_addr = ra; wr_sel = ws; wr_addr = wa; wr_data = wd; wr_bmask = wm;
    if (b_wph) begin
      model[wa] = {mrg(model[wa][35:18], wd, wm), mrg(model[wa][17:0], b_w0d, b_w0m)};
      b_wph = 0;
    end else if (ws) begin
      b_wph = 1; b_w0d = wd; b_w0m = wm;
    end
    if (b_rpend) begin
      exp_cyc.push_back(cyc + 1); exp_dat.push_back(model[b_ra][17:0]);  exp_tag.push_back(cur_tag);
      exp_cyc.push_back(cyc + 2); exp_dat.push_back(model[b_ra][35:18]); exp_tag.push_back(cur_tag);
      b_rpend = 0;
    end else if (rs) begin
      b_rpend = 1; b_ra = ra;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, 2'b00);
  endtask

  always begin
    @(posedge clk);
    cyc++;
    #(CLK_PERIOD/4);
    if (running) begin
      checks++;
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        if (!rd_valid || rd_data !== exp_dat[0]) begin
          errors++;
          $display("FAIL %s cyc %0d: valid=%b data=%h expected valid=1 data=%h",
                   exp_tag[0], cyc, rd_valid, rd_data, exp_dat[0]);
        end
        void'(exp_cyc.pop_front()); void'(exp_dat.pop_front()); void'(exp_tag.pop_front());
      end else if (rd_valid !== 1'b0 || rd_data !== 18'h0) begin
        errors++;
        $display("FAIL R4 cyc %0d: valid=%b data=%h expected valid=0 data=0",
                 cyc, rd_valid, rd_data);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 18'h0) begin
      errors++;
      $display("FAIL R1: valid=%b data=%h expected valid=0 data=0", rd_valid, rd_data);
    end
    rst_n = 1'b1;
    running = 1;
    for (int i = 0; i < DEPTH; i++) begin
      step(0, '0, 1, AW'(i), 18'(i * 7 + 3), 2'b11);
      step(0, '0, 0, AW'(i), 18'(i * 13 + 5), 2'b11);
    end
    idle(2);
    cur_tag = "R3";
    for (int i = 0; i < 8; i++) step(1, AW'(i), 0, '0, '0, 2'b00);
    idle(3);
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) step(1, AW'(i + 10), 0, '0, '0, 2'b00);
    step(0, '0, 0, '0, '0, 2'b00);
    idle(3);
    cur_tag = "R7";
    a = 5;
    step(0, '0, 1, '0, 18'h2AAAA, 2'b01);
    step(1, a, 0, a, 18'h15555, 2'b10);
    step(0, '0, 0, '0, '0, 2'b00);
    idle(3);
    step(1, a, 1, '0, 18'h3F0F0, 2'b10);
    step(0, '0, 0, a, 18'h0F0F0, 2'b01);
    idle(3);
    step(1, a, 0, '0, '0, 2'b00);
    step(0, '0, 1, '0, 18'h12345, 2'b11);
    step(0, '0, 0, a, 18'h3ABCD, 2'b11);
    idle(3);
    cur_tag = "R6";
    step(0, '0, 1, '0, 18'h3FFFF, 2'b00);
    step(0, '0, 0, AW'(6), 18'h3FFFF, 2'b00);
    step(1, AW'(6), 0, '0, '0, 2'b00);
    idle(4);
    cur_tag = "R8";
    step(0, '0, 1, '0, 18'h00111, 2'b11);
    step(1, AW'(7), 0, AW'(7), 18'h00222, 2'b11);
    step(0, '0, 0, '0, '0, 2'b00);
    idle(3);
    cur_tag = "R5";
    step(0, '0, 1, '0, 18'h0AAAA, 2'b11);
    step(0, '0, 1, AW'(8), 18'h0BBBB, 2'b11);
    step(1, AW'(8), 0, '0, '0, 2'b00);
    step(1, AW'(9), 0, '0, '0, 2'b00);
    step(1, AW'(9), 0, '0, '0, 2'b00);
    idle(4);
    cur_tag = "R9";
    for (int i = 0; i < 1200; i++)
      step($urandom_range(0, 1), AW'($urandom_range(0, 7)), $urandom_range(0, 1),
           AW'($urandom_range(0, 7)), 18'($urandom), 2'($urandom));
    idle(5);
    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d beats outstanding, expected 0", exp_cyc.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule